// File: doc/BRIEF.md
# I2C Slave Receiver with Event-Driven Clock Stretching

This block is the receive side of an I2C slave. It watches the open-drain SCL and SDA lines, finds start, repeated-start and stop conditions, shifts in bytes on rising SCL edges and matches a 7-bit or 10-bit own address. It drives the bus only through two pull-low outputs. One pulls SDA low in the acknowledge slot. The other pulls SCL low to stretch the clock.

Three hold points can each be turned on separately. The first follows a matching address byte. The second follows a received write-data byte. The third follows the acknowledge slot of any byte that belongs to this slave. When a hold point fires, the block sets a shared stretch flag and a per-event flag, then keeps SCL low. SCL stays low until software has cleared both flags with single-cycle clear strobes. During an address or data hold, software can choose between ACK and NACK through a response input before it lets the clock go. A global stretch-disable input turns every hold point off.

In 10-bit mode, the header byte of a write is acknowledged but never holds the clock. The low address byte does hold when it matches. A header byte with the read bit set is accepted, and may hold, only while a slave-active flag shows that a full 10-bit match has already been made.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, both pull-low outputs are 0, all four flags and `slave_active` are 0, and `rx_data` is 0.
- R2: In 7-bit mode, with the address hold enabled, a first byte whose upper seven bits equal `own_addr[6:0]` sets `stretch_flag` and `addr_flag` and pulls SCL low after the 8th falling SCL edge. A first byte that does not match sets no flag, does not pull SCL and is not acknowledged.
- R3: A byte received after a write address is placed on `rx_data`. With the data hold enabled, it sets `stretch_flag` and `data_flag` and pulls SCL low after its 8th falling SCL edge.
- R4: With the acknowledge hold enabled, the 9th falling SCL edge of any byte owned by this slave sets `stretch_flag` and `ack_flag` and pulls SCL low. Owned bytes are matched address bytes, write bytes and read bytes.
- R5: A held SCL is released only when both `stretch_flag` and the flag of the event that caused the hold are 0. Clearing only one of them keeps SCL low, and the bit count does not move while SCL is held.
- R6: While `stretch_dis` is 1, no hold point sets a flag or pulls SCL, and a hold that is already pending stops pulling SCL. Address and data bytes are still acknowledged.
- R7: In the acknowledge slot of an acknowledged byte, SDA is pulled low when `sw_nack` is 0 and left released when `sw_nack` is 1. The value of `sw_nack` is followed only while SCL is low, so `sda_pull` changes only while SCL is low.
- R8: In 10-bit mode, a low address byte equal to `own_addr[7:0]` that follows an acknowledged write header (`11110`, `own_addr[9:8]`, 0) sets `slave_active`. With the address hold enabled, it also causes an address hold.
- R9: In 10-bit mode, a matching header byte with R/W = 0 is acknowledged but never causes an address hold.
- R10: In 10-bit mode, a matching header byte with R/W = 1 is acknowledged, and may cause an address hold, only while `slave_active` is 1. Otherwise it is not acknowledged and does not hold.
- R11: `slave_active` is cleared by a stop condition and by an address byte that does not match.
- R12: A stop leaves all pending flags set. A start or repeated start throws away a partly received byte, so the next full byte is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Resolved SCL level seen on the bus |
| sda_in | input | 1 | Resolved SDA level seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own slave address; bits 6:0 are used in 7-bit mode |
| stretch_dis | input | 1 | 1 disables every hold point |
| addr_hold_en | input | 1 | Enables the hold after a matching address |
| data_hold_en | input | 1 | Enables the hold after a received write byte |
| ack_hold_en | input | 1 | Enables the hold after the acknowledge slot |
| sw_nack | input | 1 | Software response: 0 = ACK, 1 = NACK |
| clr_stretch | input | 1 | Strobe that clears the shared stretch flag |
| clr_addr_flag | input | 1 | Strobe that clears the address flag |
| clr_data_flag | input | 1 | Strobe that clears the write-data flag |
| clr_ack_flag | input | 1 | Strobe that clears the acknowledge-time flag |
| stretch_flag | output | 1 | Shared stretch flag |
| addr_flag | output | 1 | Address-hold event flag |
| data_flag | output | 1 | Write-data-hold event flag |
| ack_flag | output | 1 | Acknowledge-time-hold event flag |
| slave_active | output | 1 | A full 10-bit match is in effect |
| rx_data | output | 8 | Last received write byte |

## Verification
The assertions assume a well-behaved bus. The master never issues a start or stop while the slave is pulling SDA in an acknowledge slot. It keeps SCL low for more than one system clock after each falling edge. The configuration inputs do not change while a hold is pending, except for `stretch_dis`. The bus is wired as a true wired-AND, so SCL reads low whenever `scl_pull` is set. The bench's master model keeps to these rules. It changes SDA only at quarter points while SCL is low. It waits for SCL to read high before it counts a clock pulse as done. It always clears the flags before it tries to clock past a hold, and it ends transfers only outside acknowledge slots.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int OWN_W  = 10;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    // hold event indices; the flag block is sized by EV_N
    localparam int EV_ADDR = 0;
    localparam int EV_DATA = 1;
    localparam int EV_ACK  = 2;
    localparam int EV_N    = 3;

    localparam logic [4:0] TEN_TAG = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_ADDR2,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic   own;
        logic   ack_want;
        logic   addr_hit;
        logic   data_hit;
        logic   sa_set;
        logic   sa_clr;
        phase_e next;
    } byte_dec_t;

    function automatic logic ten_header_hit(input logic [BYTE_W-1:0] b,
                                            input logic [1:0] hi);
        return (b[7:3] == TEN_TAG) && (b[2:1] == hi);
    endfunction

endpackage

// File: rtl/i2cs_bus_monitor.sv
module i2cs_bus_monitor
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        ev.start = scl_q && scl_in && sda_q && !sda_in;
        ev.stop  = scl_q && scl_in && !sda_q && sda_in;
        ev.rise  = scl_in && !scl_q;
        ev.fall  = !scl_in && scl_q;
    end

endmodule

// File: rtl/i2cs_bit_engine.sv
module i2cs_bit_engine
    import i2cs_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          sda_in,
    output logic [W-1:0]  shift_q,
    output logic [CW-1:0] bit_cnt,
    output logic          ack_bit,
    output logic          byte_done,
    output logic          ack_done
);

    localparam logic [CW-1:0] LAST_DATA = CW'(W);
    localparam logic [CW-1:0] ACK_POS   = CW'(W + 1);

    // bit_cnt counts rising SCL edges since the last start or ack slot,
    // so the falling edge that follows a start is not taken as a bit
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            bit_cnt <= '0;
            ack_bit <= 1'b1;
        end else if (ev.start) begin
            shift_q <= '0;
            bit_cnt <= '0;
        end else if (ev.stop) begin
            bit_cnt <= '0;
        end else if (ev.rise) begin
            if (bit_cnt < LAST_DATA) begin
                shift_q <= {shift_q[W-2:0], sda_in};
            end else begin
                ack_bit <= sda_in;
            end
            if (bit_cnt < ACK_POS) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else if (ev.fall && bit_cnt == ACK_POS) begin
            bit_cnt <= '0;
        end
    end

    assign byte_done = ev.fall && (bit_cnt == LAST_DATA);
    assign ack_done  = ev.fall && (bit_cnt == ACK_POS);

endmodule

// File: rtl/i2cs_byte_decoder.sv
module i2cs_byte_decoder
    import i2cs_pkg::*;
(
    input  phase_e            phase,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ten_bit,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              slave_active,
    output byte_dec_t         dec
);

    always_comb begin
        dec      = '0;
        dec.next = PH_SKIP;
        unique case (phase)
            PH_ADDR1: begin
                if (!ten_bit) begin
                    if (rx_byte[7:1] == own_addr[6:0]) begin
                        dec.own      = 1'b1;
                        dec.ack_want = 1'b1;
                        dec.addr_hit = 1'b1;
                        dec.next     = rx_byte[0] ? PH_READ : PH_WRITE;
                    end else begin
                        dec.sa_clr = 1'b1;
                    end
                end else if (ten_header_hit(rx_byte, own_addr[9:8])) begin
                    if (!rx_byte[0]) begin
                        // write header: acknowledged, never a hold point
                        dec.own      = 1'b1;
                        dec.ack_want = 1'b1;
                        dec.next     = PH_ADDR2;
                    end else if (slave_active) begin
                        dec.own      = 1'b1;
                        dec.ack_want = 1'b1;
                        dec.addr_hit = 1'b1;
                        dec.next     = PH_READ;
                    end
                end else begin
                    dec.sa_clr = 1'b1;
                end
            end
            PH_ADDR2: begin
                if (rx_byte == own_addr[7:0]) begin
                    dec.own      = 1'b1;
                    dec.ack_want = 1'b1;
                    dec.addr_hit = 1'b1;
                    dec.sa_set   = 1'b1;
                    dec.next     = PH_WRITE;
                end else begin
                    dec.sa_clr = 1'b1;
                end
            end
            PH_WRITE: begin
                dec.own      = 1'b1;
                dec.ack_want = 1'b1;
                dec.data_hit = 1'b1;
                dec.next     = PH_WRITE;
            end
            PH_READ: begin
                dec.own  = 1'b1;
                dec.next = PH_READ;
            end
            default: begin
                dec.next = phase;
            end
        endcase
    end

endmodule

// File: rtl/i2cs_hold_flags.sv
module i2cs_hold_flags
    import i2cs_pkg::*;
#(
    parameter int N = EV_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stretch_dis,
    input  logic [N-1:0] en,
    input  logic [N-1:0] ev_set,
    input  logic [N-1:0] clr_ev,
    input  logic         clr_common,
    output logic         common_flag,
    output logic [N-1:0] ev_flag,
    output logic         scl_pull
);

    logic [N-1:0] arm;
    logic [N-1:0] held;
    logic         common_q;

    assign arm = ev_set & en & {N{!stretch_dis}};

    for (genvar i = 0; i < N; i++) begin : g_event
        logic flag_q;
        logic held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
                held_q <= 1'b0;
            end else begin
                if (arm[i]) begin
                    flag_q <= 1'b1;
                end else if (clr_ev[i]) begin
                    flag_q <= 1'b0;
                end
                if (arm[i]) begin
                    held_q <= 1'b1;
                end else if (!common_q && !flag_q) begin
                    held_q <= 1'b0;
                end
            end
        end

        assign ev_flag[i] = flag_q;
        assign held[i]    = held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            common_q <= 1'b0;
        end else if (|arm) begin
            common_q <= 1'b1;
        end else if (clr_common) begin
            common_q <= 1'b0;
        end
    end

    assign common_flag = common_q;
    assign scl_pull    = (|held) && !stretch_dis;

    // only one event may own the stretch at a time
    assert_single_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(held));

    assert_no_arm_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(common_q) |-> $past(!stretch_dis));

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              ten_bit_mode,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              stretch_dis,
    input  logic              addr_hold_en,
    input  logic              data_hold_en,
    input  logic              ack_hold_en,
    input  logic              sw_nack,
    input  logic              clr_stretch,
    input  logic              clr_addr_flag,
    input  logic              clr_data_flag,
    input  logic              clr_ack_flag,
    output logic              stretch_flag,
    output logic              addr_flag,
    output logic              data_flag,
    output logic              ack_flag,
    output logic              slave_active,
    output logic [BYTE_W-1:0] rx_data
);

    bus_ev_t            ev;
    logic [BYTE_W-1:0]  shift_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic               ack_bit;
    logic               byte_done;
    logic               ack_done;
    byte_dec_t          dec;

    phase_e             phase;
    logic               ack_slot;
    logic               ack_want;
    logic               own_byte;
    logic               resp_nack;
    logic               active_q;
    logic [BYTE_W-1:0]  rx_q;

    logic [EV_N-1:0]    hold_en;
    logic [EV_N-1:0]    hold_ev;
    logic [EV_N-1:0]    hold_clr;
    logic [EV_N-1:0]    hold_flag;

    i2cs_bus_monitor u_mon (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cs_bit_engine #(.W(BYTE_W), .CW(CNT_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_in    (sda_in),
        .shift_q   (shift_q),
        .bit_cnt   (bit_cnt),
        .ack_bit   (ack_bit),
        .byte_done (byte_done),
        .ack_done  (ack_done)
    );

    i2cs_byte_decoder u_dec (
        .phase        (phase),
        .rx_byte      (shift_q),
        .ten_bit      (ten_bit_mode),
        .own_addr     (own_addr),
        .slave_active (active_q),
        .dec          (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            ack_slot  <= 1'b0;
            ack_want  <= 1'b0;
            own_byte  <= 1'b0;
            resp_nack <= 1'b0;
            active_q  <= 1'b0;
            rx_q      <= '0;
        end else if (ev.start) begin
            phase    <= PH_ADDR1;
            ack_slot <= 1'b0;
            own_byte <= 1'b0;
        end else if (ev.stop) begin
            phase    <= PH_IDLE;
            ack_slot <= 1'b0;
            own_byte <= 1'b0;
            active_q <= 1'b0;
        end else if (byte_done) begin
            phase     <= dec.next;
            ack_slot  <= 1'b1;
            ack_want  <= dec.ack_want;
            own_byte  <= dec.own;
            resp_nack <= sw_nack;
            if (dec.sa_set) begin
                active_q <= 1'b1;
            end else if (dec.sa_clr) begin
                active_q <= 1'b0;
            end
            if (dec.data_hit) begin
                rx_q <= shift_q;
            end
        end else if (ack_done) begin
            ack_slot <= 1'b0;
            own_byte <= 1'b0;
            // master answered NACK on a read byte: stop taking part
            if (phase == PH_READ && ack_bit) begin
                phase <= PH_SKIP;
            end
        end else if (ack_slot && !scl_in) begin
            resp_nack <= sw_nack;
        end
    end

    always_comb begin
        hold_en           = '0;
        hold_ev           = '0;
        hold_clr          = '0;
        hold_en[EV_ADDR]  = addr_hold_en;
        hold_en[EV_DATA]  = data_hold_en;
        hold_en[EV_ACK]   = ack_hold_en;
        hold_ev[EV_ADDR]  = byte_done && dec.addr_hit;
        hold_ev[EV_DATA]  = byte_done && dec.data_hit;
        hold_ev[EV_ACK]   = ack_done && own_byte;
        hold_clr[EV_ADDR] = clr_addr_flag;
        hold_clr[EV_DATA] = clr_data_flag;
        hold_clr[EV_ACK]  = clr_ack_flag;
    end

    i2cs_hold_flags #(.N(EV_N)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .stretch_dis (stretch_dis),
        .en          (hold_en),
        .ev_set      (hold_ev),
        .clr_ev      (hold_clr),
        .clr_common  (clr_stretch),
        .common_flag (stretch_flag),
        .ev_flag     (hold_flag),
        .scl_pull    (scl_pull)
    );

    assign addr_flag    = hold_flag[EV_ADDR];
    assign data_flag    = hold_flag[EV_DATA];
    assign ack_flag     = hold_flag[EV_ACK];
    assign slave_active = active_q;
    assign rx_data      = rx_q;
    assign sda_pull     = ack_slot && ack_want && !resp_nack;

    assert_sda_edge_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_in);

    assert_count_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        scl_pull |=> $stable(bit_cnt));

    assert_release_both_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_pull) && !stretch_dis && $past(!stretch_dis) |-> $past(!stretch_flag));

    assert_hold_sets_common_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) && $past(!stretch_dis) |-> stretch_flag);

    assert_active_needs_ten_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(slave_active) |-> $past(ten_bit_mode));

endmodule

// File: tb/test_i2c_stretch_slave.sv
module test_i2c_stretch_slave;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_in, sda_in;
    logic       scl_pull, sda_pull;
    logic       ten_bit_mode = 1'b0;
    logic [9:0] own_addr = 10'h05A;
    logic       stretch_dis = 1'b0;
    logic       addr_hold_en = 1'b0, data_hold_en = 1'b0, ack_hold_en = 1'b0;
    logic       sw_nack = 1'b0;
    logic       clr_stretch = 1'b0, clr_addr_flag = 1'b0;
    logic       clr_data_flag = 1'b0, clr_ack_flag = 1'b0;
    logic       stretch_flag, addr_flag, data_flag, ack_flag, slave_active;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic seen;

    always #10 clk = ~clk;

    assign scl_in = m_scl & ~scl_pull;
    assign sda_in = m_sda & ~sda_pull;

    i2c_stretch_slave i_i2c_stretch_slave (
        .clk (clk), .rst (rst), .scl_in (scl_in), .sda_in (sda_in),
        .scl_pull (scl_pull), .sda_pull (sda_pull),
        .ten_bit_mode (ten_bit_mode), .own_addr (own_addr),
        .stretch_dis (stretch_dis), .addr_hold_en (addr_hold_en),
        .data_hold_en (data_hold_en), .ack_hold_en (ack_hold_en),
        .sw_nack (sw_nack), .clr_stretch (clr_stretch),
        .clr_addr_flag (clr_addr_flag), .clr_data_flag (clr_data_flag),
        .clr_ack_flag (clr_ack_flag), .stretch_flag (stretch_flag),
        .addr_flag (addr_flag), .data_flag (data_flag), .ack_flag (ack_flag),
        .slave_active (slave_active), .rx_data (rx_data)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        while (!scl_in) @(negedge clk);
        wq(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl_high();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl_high();
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q);
        scl_high();
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // ninth clock with the master letting SDA go; returns the level seen
    task automatic ack_clock(output logic lvl);
        m_sda = 1'b1; wq(Q);
        lvl = sda_in;
        scl_high();
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic master_ack(input logic v);
        m_sda = v; wq(Q);
        scl_high();
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic sw_clear(input logic s, input logic a, input logic d, input logic k);
        clr_stretch = s; clr_addr_flag = a; clr_data_flag = d; clr_ack_flag = k;
        wq(1);
        clr_stretch = 1'b0; clr_addr_flag = 1'b0; clr_data_flag = 1'b0; clr_ack_flag = 1'b0;
        wq(2);
    endtask

    task automatic t_reset();
        check("R1 scl_pull", scl_pull, 0);
        check("R1 sda_pull", sda_pull, 0);
        check("R1 flags", {stretch_flag, addr_flag, data_flag, ack_flag}, 0);
        check("R1 slave_active", slave_active, 0);
        check("R1 rx_data", rx_data, 0);
    endtask

    task automatic t_addr7_hold();
        own_addr = 10'h05A; addr_hold_en = 1'b1;
        bus_start();
        send_byte(8'hB4);
        check("R2 scl held", scl_pull, 1);
        check("R2 stretch_flag", stretch_flag, 1);
        check("R2 addr_flag", addr_flag, 1);
        check("R2 data_flag", data_flag, 0);
        check("R7 ack driven during hold", sda_pull, 1);
        sw_clear(1, 0, 0, 0);
        check("R5 only common cleared keeps hold", scl_pull, 1);
        sw_clear(0, 1, 0, 0);
        check("R5 both cleared releases", scl_pull, 0);
        ack_clock(seen);
        check("R7 address ack", seen, 0);
        send_byte(8'hC3);
        check("R3 no data hold when disabled", scl_pull, 0);
        ack_clock(seen);
        check("R7 data ack", seen, 0);
        check("R3 rx_data", rx_data, 8'hC3);
        bus_stop();
        addr_hold_en = 1'b0;
    endtask

    task automatic t_data_hold_nack();
        data_hold_en = 1'b1;
        bus_start();
        send_byte(8'hB4);
        check("R3 no hold on address", scl_pull, 0);
        ack_clock(seen);
        send_byte(8'h3C);
        check("R3 data hold", scl_pull, 1);
        check("R3 data_flag", data_flag, 1);
        check("R3 stretch_flag", stretch_flag, 1);
        check("R3 rx_data held byte", rx_data, 8'h3C);
        sw_nack = 1'b1;
        sw_clear(0, 0, 1, 0);
        check("R5 event flag cleared alone keeps hold", scl_pull, 1);
        check("R7 nack chosen during hold", sda_pull, 0);
        sw_clear(1, 0, 0, 0);
        check("R5 released", scl_pull, 0);
        ack_clock(seen);
        check("R7 nack on bus", seen, 1);
        bus_stop();
        sw_nack = 1'b0; data_hold_en = 1'b0;
    endtask

    task automatic t_ack_hold();
        ack_hold_en = 1'b1;
        bus_start();
        send_byte(8'hB5);
        check("R4 no hold before ack slot", scl_pull, 0);
        ack_clock(seen);
        check("R4 read address acked", seen, 0);
        check("R4 ack hold on address", scl_pull, 1);
        check("R4 ack_flag", ack_flag, 1);
        check("R4 addr_flag stays clear", addr_flag, 0);
        sw_clear(1, 0, 0, 1);
        check("R5 ack hold released", scl_pull, 0);
        send_byte(8'hFF);
        check("R4 no hold mid read byte", scl_pull, 0);
        master_ack(1'b0);
        check("R4 ack hold on read byte", scl_pull, 1);
        sw_clear(1, 0, 0, 1);
        bus_stop();
        ack_hold_en = 1'b0;
    endtask

    task automatic t_mismatch();
        addr_hold_en = 1'b1; ack_hold_en = 1'b1;
        bus_start();
        send_byte(8'h22);
        check("R2 mismatch no hold", scl_pull, 0);
        check("R2 mismatch no flags", {stretch_flag, addr_flag}, 0);
        ack_clock(seen);
        check("R2 mismatch not acked", seen, 1);
        check("R4 no ack hold for foreign byte", ack_flag, 0);
        bus_stop();
        addr_hold_en = 1'b0; ack_hold_en = 1'b0;
    endtask

    task automatic t_disable();
        stretch_dis = 1'b1; addr_hold_en = 1'b1; data_hold_en = 1'b1; ack_hold_en = 1'b1;
        bus_start();
        send_byte(8'hB4);
        check("R6 no hold", scl_pull, 0);
        check("R6 no flags", {stretch_flag, addr_flag}, 0);
        ack_clock(seen);
        check("R6 still acked", seen, 0);
        check("R6 no ack hold", {scl_pull, ack_flag}, 0);
        bus_stop();
        stretch_dis = 1'b0; addr_hold_en = 1'b0; data_hold_en = 1'b0; ack_hold_en = 1'b0;
    endtask

    task automatic t_ten_bit();
        ten_bit_mode = 1'b1; own_addr = 10'h2A5; addr_hold_en = 1'b1;
        bus_start();
        send_byte(8'hF4);
        check("R9 write header no hold", scl_pull, 0);
        check("R9 write header no flag", addr_flag, 0);
        ack_clock(seen);
        check("R9 write header acked", seen, 0);
        send_byte(8'hA5);
        check("R8 low byte hold", scl_pull, 1);
        check("R8 addr_flag", addr_flag, 1);
        check("R8 slave_active", slave_active, 1);
        sw_clear(1, 1, 0, 0);
        ack_clock(seen);
        check("R8 low byte acked", seen, 0);
        bus_start();
        send_byte(8'hF5);
        check("R10 read header hold while active", scl_pull, 1);
        check("R10 addr_flag", addr_flag, 1);
        sw_clear(1, 1, 0, 0);
        ack_clock(seen);
        check("R10 read header acked", seen, 0);
        bus_stop();
        check("R11 stop clears slave_active", slave_active, 0);
        bus_start();
        send_byte(8'hF5);
        check("R10 read header inactive no hold", scl_pull, 0);
        ack_clock(seen);
        check("R10 read header inactive not acked", seen, 1);
        bus_stop();
    endtask

    task automatic t_ten_mismatch();
        bus_start();
        send_byte(8'hF4);
        ack_clock(seen);
        send_byte(8'hA5);
        sw_clear(1, 1, 0, 0);
        ack_clock(seen);
        check("R8 active before mismatch", slave_active, 1);
        bus_start();
        send_byte(8'hF4);
        ack_clock(seen);
        send_byte(8'h00);
        check("R11 mismatch clears slave_active", slave_active, 0);
        check("R11 mismatch no hold", scl_pull, 0);
        ack_clock(seen);
        check("R11 mismatch not acked", seen, 1);
        bus_stop();
        ten_bit_mode = 1'b0; own_addr = 10'h05A; addr_hold_en = 1'b0;
    endtask

    task automatic t_stop_keeps();
        addr_hold_en = 1'b1;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'hB4);
        check("R12 byte after restart decoded", addr_flag, 1);
        stretch_dis = 1'b1; wq(2);
        check("R6 disable drops pending pull", scl_pull, 0);
        ack_clock(seen);
        bus_stop();
        check("R12 flags kept over stop", {stretch_flag, addr_flag}, 2'b11);
        sw_clear(1, 1, 0, 0);
        stretch_dis = 1'b0; wq(2);
        check("R5 no pull after clearing", scl_pull, 0);
        check("R12 flags cleared by software", {stretch_flag, addr_flag}, 0);
        addr_hold_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wq(5);
        rst = 1'b0;
        wq(3);
        t_reset();
        t_addr7_hold();
        t_data_hold_nack();
        t_ack_hold();
        t_mismatch();
        t_disable();
        t_ten_bit();
        t_ten_mismatch();
        t_stop_keeps();
        wq(10);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule